// File: doc/BRIEF.md
# Charge-Controlled Symmetric Half-Bridge Gate Timer

The block drives the two gates of a resonant half-bridge under charge-mode control. Each switching cycle opens with a dead-time and then turns on the high-side gate. The high side stays on until an external comparator reports that the integrated resonant current has reached its threshold. The block counts that on-time in clock ticks, corrects it for capture latency, bounds it, and then holds the low-side gate on for the same number of ticks. This makes both halves of the period equal.

A maximum half-period input sets the lowest switching frequency. If no comparator event arrives in time, the high side is cut off at that limit. At light load, a mode input selects a fixed half-period supplied from outside, and the comparator is ignored. A blanking window at the start of each high-side interval rejects comparator edges caused by switching noise. The integrator, the threshold DAC and the outer voltage loop all sit outside the block.

Top module: `cm_halfbridge_pwm`

## Requirements
- R1: In current mode, the high-side gate rises after the leading dead-time. It falls on the third rising clock edge after an accepted rising edge of `cmp_i` (two synchronizer flops plus one edge flop). If `cmp_i` is raised just before the D-th high sample, the high-side pulse therefore lasts D+2 ticks.
- R2: The low-side pulse lasts exactly `ton_o` ticks. `ton_o` is the on-time captured at the end of the preceding high-side pulse.
- R3: A new high-side pulse starts only after the low-side pulse has completed and one dead-time has elapsed.
- R4: The high-side pulse never exceeds `max_half_i` ticks. If no comparator event is accepted, the pulse ends at exactly `max_half_i` ticks.
- R5: Both gates are low for exactly `dead_i` ticks between the high-side fall and the low-side rise, and again between the low-side fall and the next high-side rise. A `dead_i` of 0 acts as 1.
- R6: With `vmode_i`=1, `cmp_i` has no effect. Both pulses last min(`vm_half_i`, `max_half_i`) ticks, and no offset or minimum is applied.
- R7: In current mode, the captured on-time is the high-side length minus `comp_ofs_i`, saturating at zero, before the bounds of R9 are applied.
- R8: Only a rising edge of `cmp_i` counts. An edge that falls in the dead-time or the low-side pulse is ignored. An edge seen while the high-side tick counter (0 on the first high tick) is below `min_on_i` is also ignored.
- R9: In current mode, the captured on-time is raised to at least max(`min_on_i`, 1) and then limited to at most `max_half_i`.
- R10: While `rst_ni` is low or `en_i` is low, both gates are low and the sequence returns to idle. `ton_o` resets to 0. The first clock edge with `en_i` high starts a dead-time of `dead_i` ticks, followed by a high-side pulse.
- R11: The two gates are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces both gates off |
| cmp_i | input | 1 | Asynchronous comparator output, charge above threshold |
| max_half_i | input | CNT_W | Longest half-period in ticks |
| dead_i | input | CNT_W | Dead-time in ticks |
| vmode_i | input | 1 | 1: fixed half-period mode, 0: charge mode |
| vm_half_i | input | CNT_W | Half-period used in fixed mode |
| comp_ofs_i | input | CNT_W | Latency correction subtracted from the capture |
| min_on_i | input | CNT_W | Blanking length and lower bound of the capture |
| gate_hi_o | output | 1 | High-side gate drive |
| gate_lo_o | output | 1 | Low-side gate drive |
| ton_o | output | CNT_W | Last captured on-time in ticks |

## Verification
The bench builds the block with its defaults: a 16-bit tick counter and a two-flop synchronizer. It programs a 40-tick ceiling, so every forced-limit case finishes within a few dozen cycles. Because thresholds, offsets and dead-times are run-time inputs, a single build covers dead-times of 1, 3 and 7 ticks, a blanking window that swallows an early edge, an offset that pulls the capture below the minimum, and a fixed half-period both under and over the ceiling. Events injected during the low-side pulse, and a disable in the middle of a high pulse, are reached as directed cases.

// File: rtl/hb_pwm_pkg.sv
package hb_pwm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DT_PRE,
    PH_HIGH,
    PH_DT_MID,
    PH_LOW
  } phase_e;
endpackage

// File: rtl/hb_edge_sync.sv
module hb_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-1:0], async_i};
  end

  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];

  // R8
  edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/hb_ontime_calc.sv
module hb_ontime_calc #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             vmode_i,
  input  logic [CNT_W-1:0] raw_i,
  input  logic [CNT_W-1:0] ofs_i,
  input  logic [CNT_W-1:0] min_on_i,
  input  logic [CNT_W-1:0] max_half_i,
  output logic [CNT_W-1:0] ton_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] sub_v, floor_v, lo_v, hi_v;

  always_comb begin
    sub_v   = (raw_i > ofs_i) ? raw_i - ofs_i : '0;
    floor_v = (min_on_i == '0) ? ONE : min_on_i;
    lo_v    = (sub_v < floor_v) ? floor_v : sub_v;
    hi_v    = (lo_v > max_half_i) ? max_half_i : lo_v;
    ton_o   = vmode_i ? raw_i : hi_v;
  end
endmodule

// File: rtl/cm_halfbridge_pwm.sv
module cm_halfbridge_pwm
  import hb_pwm_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cmp_i,
  input  logic [CNT_W-1:0] max_half_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic             vmode_i,
  input  logic [CNT_W-1:0] vm_half_i,
  input  logic [CNT_W-1:0] comp_ofs_i,
  input  logic [CNT_W-1:0] min_on_i,
  output logic             gate_hi_o,
  output logic             gate_lo_o,
  output logic [CNT_W-1:0] ton_o
);
  localparam int unsigned CW1 = CNT_W + 1;

  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] ton_q, ton_d, ton_calc;
  logic [CW1-1:0]   cnt_inc, hi_lim;
  logic             cmp_rise, accept, hi_done;
  logic             gate_hi_q, gate_lo_q;

  hb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(cmp_i),
    .rise_o (cmp_rise)
  );

  hb_ontime_calc #(.CNT_W(CNT_W)) u_calc (
    .vmode_i   (vmode_i),
    .raw_i     (cnt_inc[CNT_W-1:0]),
    .ofs_i     (comp_ofs_i),
    .min_on_i  (min_on_i),
    .max_half_i(max_half_i),
    .ton_o     (ton_calc)
  );

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + CW1'(1);
    if (vmode_i && (vm_half_i < max_half_i)) hi_lim = {1'b0, vm_half_i};
    else                                     hi_lim = {1'b0, max_half_i};
    accept  = !vmode_i && cmp_rise && (cnt_q >= min_on_i);
    hi_done = accept || (cnt_inc >= hi_lim);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CNT_W'(1);
    ton_d   = ton_q;
    if (!en_i) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PH_IDLE: begin
          state_d = PH_DT_PRE;
          cnt_d   = '0;
        end
        PH_DT_PRE: if (cnt_inc >= {1'b0, dead_i}) begin
          state_d = PH_HIGH;
          cnt_d   = '0;
        end
        PH_HIGH: if (hi_done) begin
          state_d = PH_DT_MID;
          cnt_d   = '0;
          ton_d   = ton_calc;
        end
        PH_DT_MID: if (cnt_inc >= {1'b0, dead_i}) begin
          state_d = PH_LOW;
          cnt_d   = '0;
        end
        PH_LOW: if (cnt_inc >= {1'b0, ton_q}) begin
          state_d = PH_DT_PRE;
          cnt_d   = '0;
        end
        default: begin
          state_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PH_IDLE;
      cnt_q     <= '0;
      ton_q     <= '0;
      gate_hi_q <= 1'b0;
      gate_lo_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      ton_q     <= ton_d;
      // gates registered from next phase: glitch-free, aligned with state_q
      gate_hi_q <= (state_d == PH_HIGH);
      gate_lo_q <= (state_d == PH_LOW);
    end
  end

  assign gate_hi_o = gate_hi_q;
  assign gate_lo_o = gate_lo_q;
  assign ton_o     = ton_q;

  // R11
  gate_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_hi_o && gate_lo_o));

  // R5
  hi_to_lo_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_hi_o) |-> !gate_lo_o);

  // R4
  hi_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_HIGH && max_half_i != '0) |-> (cnt_q < max_half_i));

  // R2
  low_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_LOW) |-> (cnt_inc <= {1'b0, ton_q}));

  // R10
  off_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!gate_hi_o && !gate_lo_o));

  // R3
  low_then_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_lo_o) |-> !gate_hi_o);
endmodule

// File: tb/cm_halfbridge_pwm_tb_top.sv
`timescale 1ns/1ps
module cm_halfbridge_pwm_tb_top;
  localparam int W = 16;

  typedef struct packed {
    logic        vm;
    logic [15:0] d, mn, of, mx, vh, dt, eh, el;
    logic [3:0]  rq;
  } vec_t;

  // vm, d, min_on, ofs, max, vm_half, dead, exp_hi, exp_lo, req
  localparam vec_t VECS [11] = '{
    '{1'b0, 16'd6,  16'd2,  16'd0, 16'd40, 16'd20, 16'd3, 16'd8,  16'd8,  4'd1}, // R1 R2
    '{1'b0, 16'd15, 16'd2,  16'd0, 16'd40, 16'd20, 16'd3, 16'd17, 16'd17, 4'd2}, // R2
    '{1'b0, 16'd0,  16'd2,  16'd0, 16'd40, 16'd20, 16'd3, 16'd40, 16'd40, 4'd4}, // R4 no event
    '{1'b0, 16'd38, 16'd2,  16'd0, 16'd40, 16'd20, 16'd3, 16'd40, 16'd40, 4'd4}, // R4 edge at limit
    '{1'b0, 16'd3,  16'd10, 16'd0, 16'd40, 16'd20, 16'd3, 16'd40, 16'd40, 4'd8}, // R8 blanking
    '{1'b0, 16'd10, 16'd2,  16'd2, 16'd40, 16'd20, 16'd3, 16'd12, 16'd10, 4'd7}, // R7 offset
    '{1'b0, 16'd4,  16'd5,  16'd4, 16'd40, 16'd20, 16'd3, 16'd6,  16'd5,  4'd9}, // R9 floor
    '{1'b1, 16'd5,  16'd2,  16'd0, 16'd40, 16'd20, 16'd3, 16'd20, 16'd20, 4'd6}, // R6 fixed
    '{1'b1, 16'd5,  16'd2,  16'd0, 16'd40, 16'd60, 16'd3, 16'd40, 16'd40, 4'd6}, // R6 capped
    '{1'b0, 16'd6,  16'd2,  16'd0, 16'd40, 16'd20, 16'd1, 16'd8,  16'd8,  4'd5}, // R5 short dead
    '{1'b0, 16'd2,  16'd0,  16'd0, 16'd40, 16'd20, 16'd7, 16'd4,  16'd4,  4'd5}  // R5 long dead
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0, cmp_i = 1'b0, vmode_i = 1'b0;
  logic [W-1:0] max_half_i = 16'd40, dead_i = 16'd3, vm_half_i = 16'd20;
  logic [W-1:0] comp_ofs_i = '0, min_on_i = 16'd2;
  logic gate_hi_o, gate_lo_o;
  logic [W-1:0] ton_o;

  int total = 0, bad = 0;
  bit overlap_seen = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cm_halfbridge_pwm dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cmp_i(cmp_i),
    .max_half_i(max_half_i), .dead_i(dead_i), .vmode_i(vmode_i),
    .vm_half_i(vm_half_i), .comp_ofs_i(comp_ofs_i), .min_on_i(min_on_i),
    .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o), .ton_o(ton_o)
  );

  always @(negedge clk_i) if (gate_hi_o && gate_lo_o) overlap_seen = 1'b1;

  task automatic chk(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called at a negedge; measures one full cycle
  task automatic run_cycle(input int d, input bit lo_raise,
                           output int h, output int l, output int g0,
                           output int g1, output int g2);
    g0 = 0; while (!gate_hi_o) begin g0++; @(negedge clk_i); end
    h = 0;
    while (gate_hi_o) begin
      h++;
      if (d > 0 && h == d) cmp_i = 1'b1;
      @(negedge clk_i);
    end
    cmp_i = 1'b0;
    g1 = 0; while (!gate_lo_o) begin g1++; @(negedge clk_i); end
    l = 0;
    while (gate_lo_o) begin
      if (lo_raise && l == 1) cmp_i = 1'b1;
      l++;
      @(negedge clk_i);
    end
    g2 = 0; while (!gate_hi_o) begin g2++; @(negedge clk_i); end
  endtask

  task automatic restart(input vec_t v);
    en_i = 1'b0; cmp_i = 1'b0;
    repeat (3) @(negedge clk_i);
    vmode_i = v.vm; min_on_i = v.mn; comp_ofs_i = v.of;
    max_half_i = v.mx; vm_half_i = v.vh; dead_i = v.dt;
    en_i = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int h, l, g0, g1, g2;
    string rq;
    en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10", gate_hi_o, 0, "hi in reset");
    chk("R10", gate_lo_o, 0, "lo in reset");
    chk("R10", ton_o, 0, "ton in reset");
    en_i = 1'b0;
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R10", gate_hi_o | gate_lo_o, 0, "gates with en low");

    foreach (VECS[i]) begin
      rq = $sformatf("R%0d", VECS[i].rq);
      restart(VECS[i]);
      run_cycle(VECS[i].d, 1'b0, h, l, g0, g1, g2);
      chk(rq, g0, VECS[i].dt, "lead dead");          // R10 R5
      chk(rq, h, VECS[i].eh, "hi len");              // R1
      chk(rq, g1, VECS[i].dt, "mid dead");           // R5
      chk(rq, l, VECS[i].el, "lo len");              // R2
      chk(rq, g2, VECS[i].dt, "trail dead");         // R3
      chk(rq, ton_o, VECS[i].el, "ton_o");           // R2
      run_cycle(VECS[i].d, 1'b0, h, l, g0, g1, g2);
      chk(rq, h, VECS[i].eh, "hi len 2nd");
      chk(rq, l, VECS[i].el, "lo len 2nd");
    end

    // R8 edge during low side ignored; next high runs to the limit
    restart('{1'b0, 16'd6, 16'd2, 16'd0, 16'd40, 16'd20, 16'd3, 16'd8, 16'd8, 4'd8});
    run_cycle(6, 1'b1, h, l, g0, g1, g2);
    chk("R8", l, 8, "lo len with edge in lo");
    run_cycle(0, 1'b0, h, l, g0, g1, g2);
    chk("R8", h, 40, "hi after edge in lo");
    chk("R8", l, 40, "lo after edge in lo");

    // R10 disable during high side
    restart('{1'b0, 16'd0, 16'd2, 16'd0, 16'd40, 16'd20, 16'd3, 16'd40, 16'd40, 4'd10});
    while (!gate_hi_o) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R10", gate_hi_o, 0, "hi after disable");
    repeat (5) @(negedge clk_i);
    chk("R10", gate_lo_o, 0, "lo after disable");

    chk("R11", overlap_seen, 0, "gate overlap");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule